// File: doc/BRIEF.md
# Sixteen-Bit Load/Store Register Processor

This block is a small multi-cycle processor core with sixteen-bit data. It holds eight general registers: register 0 is hard-wired to zero and register 7 is the program counter. Arithmetic and logic instructions work only on registers. Only load and store instructions reach main memory, through a single word-addressed port with separate read and write strobes.

Every instruction spends one cycle in FETCH and one in EXECUTE. Loads and stores take a third cycle, MEMORY. The effective address is formed in EXECUTE and the transfer happens in MEMORY. An instruction can carry a set-flags bit. When that bit is set, the instruction updates the negative, zero, overflow and carry flags. Conditional branches test these flags. Any result written into register 7 redirects the program.

Top module: `cpu16_core`

## Requirements
- R1: While reset is low at a clock edge the core enters FETCH with register 7 at 0 and all four flags clear; the first fetch after reset reads address 0.
- R2: In FETCH the core reads memory at register 7 with the read strobe high, latches the word as the instruction and increments register 7 by one; register 7 read as an operand later in the instruction therefore gives the address of the next word.
- R3: Register 0 reads as zero; a result addressed to it is discarded.
- R4: Instruction bits [15:13] select ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5; bit 12 is the set-flags bit, bit 11 selects a sign-extended immediate in [4:0] instead of register [4:2], [10:8] is the destination and [7:5] the first operand. SUB computes a + ~b + 1, ADC adds the carry flag, SBC computes a + ~b + carry flag; C is the carry out of the adder.
- R5: N, Z, V and C change only in an ALU instruction whose set-flags bit is 1; V is signed overflow of the adder, and AND or OR clear V and C. Every other instruction leaves the flags unchanged.
- R6: Bits [15:13]=6 encode a memory operation, with bit 12 set for store and clear for load. The address is register [7:5] plus register [4:2], or plus the sign-extended [4:0] when bit 11 is set. The access happens in the cycle after EXECUTE. Read and write strobes are never high together, and no other instruction raises a strobe after its fetch.
- R7: Bits [15:13]=7 encode a branch with condition [11:8] and a signed offset [7:0]. The condition codes are 0 always, 1 never, 2 Z, 3 not Z, 4 C, 5 not C, 6 N, 7 not N, 8 V, 9 not V, 10 N==V, 11 N!=V, 12 not Z and N==V, 13 its inverse, 14 C and not Z, 15 its inverse. A taken branch adds the offset to the incremented register 7. A branch that is not taken leaves it unchanged.
- R8: An ALU result or loaded word with destination register 7 becomes the address of the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |

## Verification
Two functions share one EXECUTE cycle: an ALU instruction with the set-flags bit can write register 7, so a flag update and a jump happen on the same edge. The bench provokes this with a flag-setting add of register 7 and an immediate. It then branches on the flags that add should have produced, and marker stores record the path taken. A load into register 7 covers the other way a jump can arrive. Each store is compared in order against a scoreboard queue, so a skipped, extra or wrong store shows up as a mismatch.

// File: rtl/cpu16_pkg.sv
// Shared types for the sixteen-bit core: opcodes, controller phases, flags
// and the branch-condition evaluator. Assumes a 16-bit instruction word.
package cpu16_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_MEM = 3'd6,
        OP_BR  = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_MEM   = 2'd2
    } phase_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Evaluate a 4-bit branch condition; bit 0 inverts the base test.
    function automatic logic cond_met(input logic [3:0] cc, input flags_t f);
        logic base;
        case (cc[3:1])
            3'd0:    base = 1'b1;
            3'd1:    base = f.z;
            3'd2:    base = f.c;
            3'd3:    base = f.n;
            3'd4:    base = f.v;
            3'd5:    base = (f.n == f.v);
            3'd6:    base = !f.z && (f.n == f.v);
            default: base = f.c && !f.z;
        endcase
        return base ^ cc[0];
    endfunction

endpackage

// File: rtl/cpu16_regfile.sv
// Register file: NREG words of W bits, three read ports, one write port.
// Entry 0 is never written and so always reads zero; the highest entry is
// the program counter and is also brought out on its own port.
module cpu16_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd,
    input  logic [$clog2(NREG)-1:0] ra_a,
    output logic [W-1:0]            rd_a,
    input  logic [$clog2(NREG)-1:0] ra_b,
    output logic [W-1:0]            rd_b,
    input  logic [$clog2(NREG)-1:0] ra_c,
    output logic [W-1:0]            rd_c,
    output logic [W-1:0]            pc
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] q [NREG];

    // Storage update: clear on reset, drop writes aimed at entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) q[i] <= '0;
        end else if (we && (wa != '0)) begin
            q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : q[ra_b];
    assign rd_c = (ra_c == '0) ? '0 : q[ra_c];
    assign pc   = q[AW'(NREG-1)];

endmodule

// File: rtl/cpu16_alu.sv
// Adder-based ALU for the six register operations. Subtracts invert b;
// the carry-in comes from the opcode or the current carry flag. Logic
// operations clear V and C.
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  opc_e         op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in_flag,
    output logic [W-1:0] res,
    output flags_t       fl
);
    logic [W-1:0] bx;
    logic [W:0]   sum;
    logic         cin;

    // Operand conditioning and carry-in choice per opcode.
    always_comb begin
        bx  = (op == OP_SUB || op == OP_SBC) ? ~b : b;
        case (op)
            OP_SUB:         cin = 1'b1;
            OP_ADC, OP_SBC: cin = c_in_flag;
            default:        cin = 1'b0;
        endcase
        sum = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
    end

    // Result and flag formation.
    always_comb begin
        case (op)
            OP_AND: begin res = a & b; fl.c = 1'b0; fl.v = 1'b0; end
            OP_OR:  begin res = a | b; fl.c = 1'b0; fl.v = 1'b0; end
            default: begin
                res  = sum[W-1:0];
                fl.c = sum[W];
                fl.v = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
            end
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
    end

endmodule

// File: rtl/cpu16_ctrl.sv
// Phase sequencer: FETCH -> EXECUTE -> (MEMORY only for memory opcodes)
// -> FETCH. Assumes the opcode input is valid during EXECUTE.
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  opc_e   op,
    output phase_e phase
);
    phase_e nxt;

    // Next-phase decision.
    always_comb begin
        case (phase)
            PH_FETCH: nxt = PH_EXEC;
            PH_EXEC:  nxt = (op == OP_MEM) ? PH_MEM : PH_FETCH;
            default:  nxt = PH_FETCH;
        endcase
    end

    // Phase register with synchronous reset into FETCH.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= nxt;
    end

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> phase == PH_FETCH);

    assert_mem_after_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_MEM |-> $past(phase) == PH_EXEC);

endmodule

// File: rtl/cpu16_core.sv
// Top of the sixteen-bit load/store core. Decodes the latched instruction,
// steers the single register-file write port per phase, forms effective
// addresses and branch targets, and holds the flags. Assumes memory read
// data is valid in the same cycle as mem_addr (asynchronous read).
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_rd,
    output logic         mem_wr
);
    localparam int            AW     = $clog2(NREG);
    localparam logic [AW-1:0] PC_IDX = AW'(NREG-1);

    phase_e        phase;
    logic [W-1:0]  ir, ea, pc, opa, opb_reg, store_val, opb, alu_res;
    flags_t        flags, alu_fl;
    opc_e          opc;
    logic          sbit, immsel, is_alu, taken;
    logic [AW-1:0] f_rd, f_ra, f_rb;
    logic          rf_we;
    logic [AW-1:0] rf_wa;
    logic [W-1:0]  rf_wd;

    assign opc    = opc_e'(ir[15:13]);
    assign sbit   = ir[12];
    assign immsel = ir[11];
    assign f_rd   = ir[10:8];
    assign f_ra   = ir[7:5];
    assign f_rb   = ir[4:2];
    assign is_alu = (opc != OP_MEM) && (opc != OP_BR);
    assign taken  = cond_met(ir[11:8], flags);
    assign opb    = immsel ? {{(W-5){ir[4]}}, ir[4:0]} : opb_reg;

    cpu16_ctrl u_ctrl (.clk(clk), .rst_n(rst_n), .op(opc), .phase(phase));

    cpu16_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
        .ra_a(f_ra), .rd_a(opa), .ra_b(f_rb), .rd_b(opb_reg),
        .ra_c(f_rd), .rd_c(store_val), .pc(pc));

    cpu16_alu #(.W(W)) u_alu (
        .op(opc), .a(opa), .b(opb), .c_in_flag(flags.c),
        .res(alu_res), .fl(alu_fl));

    // Write-port steering: PC increment, ALU result, branch target, load.
    always_comb begin
        rf_we = 1'b0;
        rf_wa = PC_IDX;
        rf_wd = pc + W'(1);
        case (phase)
            PH_FETCH: rf_we = 1'b1;
            PH_EXEC: begin
                if (is_alu) begin
                    rf_we = 1'b1;
                    rf_wa = f_rd;
                    rf_wd = alu_res;
                end else if (opc == OP_BR && taken) begin
                    rf_we = 1'b1;
                    rf_wd = pc + {{(W-8){ir[7]}}, ir[7:0]};
                end
            end
            default: begin
                rf_we = !sbit;
                rf_wa = f_rd;
                rf_wd = mem_rdata;
            end
        endcase
    end

    // Instruction latch, effective address and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir    <= '0;
            ea    <= '0;
            flags <= '0;
        end else begin
            if (phase == PH_FETCH) ir <= mem_rdata;
            if (phase == PH_EXEC && opc == OP_MEM) ea <= opa + opb;
            if (phase == PH_EXEC && is_alu && sbit) flags <= alu_fl;
        end
    end

    assign mem_addr  = (phase == PH_MEM) ? ea : pc;
    assign mem_rd    = (phase == PH_FETCH) || (phase == PH_MEM && !sbit);
    assign mem_wr    = (phase == PH_MEM) && sbit;
    assign mem_wdata = store_val;

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_FETCH |=> pc == $past(pc) + W'(1));

    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase == PH_EXEC && is_alu && sbit) |=> $stable(flags));

    assert_br_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && opc == OP_BR && !taken) |=> $stable(pc));

endmodule

// File: tb/sim_cpu16_core.sv
// Scoreboard bench: a driver loads a program and queues the stores it must
// produce; a monitor pops and compares each store as the core issues it.
module sim_cpu16_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem [256];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic [15:0] d;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    cpu16_core u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr));

    function automatic logic [15:0] i_alu(input logic [2:0] op, input logic s,
        input logic im, input logic [2:0] rd, input logic [2:0] ra, input logic [4:0] x);
        return {op, s, im, rd, ra, x};
    endfunction
    function automatic logic [15:0] i_mem(input logic st, input logic im,
        input logic [2:0] rd, input logic [2:0] ra, input logic [4:0] x);
        return {3'b110, st, im, rd, ra, x};
    endfunction
    function automatic logic [15:0] i_br(input logic [3:0] cc, input logic [7:0] off);
        return {3'b111, 1'b0, cc, off};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic [15:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: every write strobe is compared against the queue head.
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected store addr", mem_addr, 16'hxxxx);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(mem_addr == e.a, e.tag, "store address", mem_addr, e.a);
                check(mem_wdata == e.d, e.tag, "store data", mem_wdata, e.d);
            end
        end
    end

    task automatic load_program();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[0]  = i_br(4'd3, 8'd8);                     // NE, taken from reset (R1)
        mem[1]  = 16'h7FFF; mem[2] = 16'h0001; mem[3] = 16'h8000;
        mem[4]  = 16'hFFFF; mem[5] = 16'h1234; mem[6] = 16'h00F0;
        mem[7]  = 16'h0F0F; mem[8] = 16'd58;
        mem[9]  = i_mem(0, 1, 3'd1, 3'd0, 5'd1);        // r1 = 7FFF
        mem[10] = i_mem(0, 1, 3'd2, 3'd0, 5'd2);        // r2 = 1
        mem[11] = i_alu(3'd0, 0, 1, 3'd5, 3'd0, 5'd8);  // r5 = 8
        mem[12] = i_alu(3'd0, 0, 0, 3'd5, 3'd5, {3'd5, 2'b00});
        mem[13] = i_alu(3'd0, 0, 0, 3'd5, 3'd5, {3'd5, 2'b00});
        mem[14] = i_alu(3'd0, 0, 0, 3'd5, 3'd5, {3'd5, 2'b00}); // r5 = 64
        mem[15] = i_alu(3'd0, 1, 0, 3'd3, 3'd1, {3'd2, 2'b00}); // ADDS -> 8000 V N
        mem[16] = i_mem(1, 1, 3'd3, 3'd5, 5'd0);
        mem[17] = i_br(4'd8, 8'd1);                     // VS taken
        mem[18] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);        // must be skipped
        mem[19] = i_alu(3'd0, 0, 1, 3'd4, 3'd0, 5'd1);
        mem[20] = i_mem(1, 1, 3'd4, 3'd5, 5'd2);
        mem[21] = i_alu(3'd0, 0, 1, 3'd4, 3'd0, 5'd0);  // zero result, no S
        mem[22] = i_br(4'd2, 8'd1);                     // EQ must not be taken
        mem[23] = i_alu(3'd0, 0, 1, 3'd4, 3'd0, 5'd3);
        mem[24] = i_mem(1, 1, 3'd4, 3'd5, 5'd3);
        mem[25] = i_alu(3'd2, 1, 0, 3'd3, 3'd2, {3'd2, 2'b00}); // SUBS 0, C=1 Z=1
        mem[26] = i_br(4'd4, 8'd1);                     // CS taken
        mem[27] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[28] = i_br(4'd2, 8'd1);                     // EQ taken
        mem[29] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[30] = i_alu(3'd2, 1, 0, 3'd3, 3'd0, {3'd2, 2'b00}); // 0-1 = FFFF, C=0
        mem[31] = i_alu(3'd3, 1, 0, 3'd4, 3'd2, {3'd0, 2'b00}); // 1+FFFF+0 = 0, C=1
        mem[32] = i_mem(1, 1, 3'd3, 3'd5, 5'd4);
        mem[33] = i_mem(1, 1, 3'd4, 3'd5, 5'd5);
        mem[34] = i_alu(3'd1, 1, 0, 3'd4, 3'd2, {3'd2, 2'b00}); // 1+1+1 = 3
        mem[35] = i_mem(1, 1, 3'd4, 3'd5, 5'd6);
        mem[36] = i_mem(0, 1, 3'd1, 3'd0, 5'd6);        // r1 = 00F0
        mem[37] = i_mem(0, 1, 3'd2, 3'd0, 5'd7);        // r2 = 0F0F
        mem[38] = i_alu(3'd4, 0, 0, 3'd3, 3'd1, {3'd2, 2'b00});
        mem[39] = i_alu(3'd5, 0, 0, 3'd4, 3'd1, {3'd2, 2'b00});
        mem[40] = i_mem(1, 1, 3'd3, 3'd5, 5'd7);
        mem[41] = i_mem(1, 1, 3'd4, 3'd5, 5'd8);
        mem[42] = i_alu(3'd0, 0, 1, 3'd0, 3'd0, 5'd5);  // write to r0 dropped
        mem[43] = i_mem(1, 1, 3'd0, 3'd5, 5'd9);
        mem[44] = i_alu(3'd0, 0, 1, 3'd6, 3'd0, 5'd11);
        mem[45] = i_mem(1, 0, 3'd4, 3'd5, {3'd6, 2'b00}); // reg offset -> 75
        mem[46] = i_mem(1, 1, 3'd4, 3'd5, 5'h1F);       // imm -1 -> 63
        mem[47] = i_alu(3'd0, 1, 1, 3'd7, 3'd7, 5'd2);  // ADDS r7: jump + flags
        mem[48] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[49] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[50] = i_br(4'd5, 8'd1);                     // CC taken
        mem[51] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[52] = i_br(4'd6, 8'd1);                     // MI not taken
        mem[53] = i_alu(3'd0, 0, 1, 3'd4, 3'd0, 5'd7);
        mem[54] = i_mem(1, 1, 3'd4, 3'd5, 5'd10);
        mem[55] = i_mem(0, 1, 3'd7, 3'd0, 5'd8);        // load into r7 -> 58
        mem[56] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[57] = i_mem(1, 1, 3'd0, 3'd5, 5'd1);
        mem[58] = i_mem(1, 1, 3'd1, 3'd5, 5'd12);
        mem[59] = i_br(4'd0, 8'hFF);                    // park
        push(16'd64, 16'h8000, "R4 ADDS overflow result");
        push(16'd66, 16'h0001, "R7 VS branch");
        push(16'd67, 16'h0003, "R5 flags held without S");
        push(16'd68, 16'hFFFF, "R4 SUB borrow");
        push(16'd69, 16'h0000, "R4 SBC carry-in");
        push(16'd70, 16'h0003, "R4 ADC carry-in");
        push(16'd71, 16'h0000, "R4 AND");
        push(16'd72, 16'h0FFF, "R4 OR");
        push(16'd73, 16'h0000, "R3 r0 write dropped");
        push(16'd75, 16'h0FFF, "R6 register offset");
        push(16'd63, 16'h0FFF, "R6 negative immediate");
        push(16'd74, 16'h0007, "R8 ALU jump with flags");
        push(16'd76, 16'h00F0, "R8 load jump");
    endtask

    task automatic run_once();
        rst_n = 1'b0;
        load_program();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_addr == 16'd0, "R1", "reset fetch addr", mem_addr, 16'd0);
        check(mem_rd && !mem_wr, "R1", "reset strobes", {14'd0, mem_rd, mem_wr}, 16'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_rd && !mem_wr, "R6", "branch exec strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
        @(negedge clk);
        check(mem_addr == 16'd9 && mem_rd, "R2", "fetch after branch", mem_addr, 16'd9);
        repeat (400) @(negedge clk);
        check(sb.size() == 0, "R8", "stores left pending", 16'(sb.size()), 16'd0);
        sb.delete();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        run_once();
        run_once();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired", 16'd0, 16'd1);
            finish_run();
        end
    end

endmodule